// File: doc/BRIEF.md
# Serial-Access User Flash Memory

This block models a small non-volatile user memory. It holds 512 words of 16 bits, which is 8,192 bits. The words are reached through two serial shift registers, one for the address and one for the data, and each register has its own strobe, shift-enable and serial input. The 9-bit address selects a word. The 16-bit data register either captures the selected word in parallel or shifts bits in and out. A strobe on the address register with shift disabled steps the address by one, so a host can walk through consecutive words without sending a new address each time.

Program and erase requests start an operation, and a busy flag covers the time the operation takes. A program clears bits of the addressed word and never sets them. An erase restores one half of the array, a sector, to all ones. An internal oscillator sets how long busy lasts, and its output reaches a pin only while the enable input is high. All of the block's logic runs on one system clock with a synchronous active-high reset. The serial strobes are sampled on that clock, and their rising edges are detected there. Storage is made of plain registers that reset to the erased value.

Top module: `ufm_serial_mem`

## Requirements
- R1: After reset the address register is 0, the data register is 0 (so `data_sout` is 0), `busy` is 0 and every word reads 16'hFFFF.
- R2: A rising edge of `addr_sclk` while `addr_shift_en` is 1 shifts the address left by one bit and places `addr_sin` in bit 0. An address is therefore sent MSB first in 9 strobes.
- R3: A rising edge of `addr_sclk` while `addr_shift_en` is 0 adds one to the address, and address 511 wraps to 0.
- R4: A rising edge of `data_sclk` while `data_shift_en` is 0 loads the word at the current address into the data register.
- R5: `data_sout` always shows bit 15 of the data register. A rising edge of `data_sclk` while `data_shift_en` is 1 shifts the register left by one bit and places `data_sin` in bit 0.
- R6: When `prog_req` is high and `busy` is low, the addressed word becomes its old value ANDed with the data register. A program can only change bits from 1 to 0.
- R7: When `erase_req` is high and `busy` is low, every word in the sector of the current address becomes 16'hFFFF. Address bit 8 selects the sector: 0 to 255 is sector 0 and 256 to 511 is sector 1. The other sector keeps its contents.
- R8: From the cycle after an accepted request, `busy` stays high for `BUSY_TICKS` oscillator periods, give or take one period, and then returns low.
- R9: A program or erase request made while `busy` is high has no effect on the array. If both requests arrive together while idle, the program is performed.
- R10: `osc_out` is 0 whenever `osc_en` is 0. While `osc_en` is 1, `osc_out` toggles every `OSC_HALF` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sclk | input | 1 | Address register strobe; acts on its rising edge |
| addr_shift_en | input | 1 | 1 = shift the address, 0 = increment it |
| addr_sin | input | 1 | Serial address input |
| data_sclk | input | 1 | Data register strobe; acts on its rising edge |
| data_shift_en | input | 1 | 1 = shift the data register, 0 = load it in parallel |
| data_sin | input | 1 | Serial data input |
| data_sout | output | 1 | Serial data output (bit 15 of the data register) |
| prog_req | input | 1 | Program request |
| erase_req | input | 1 | Sector erase request |
| busy | output | 1 | High while a program or erase is in progress |
| osc_en | input | 1 | Oscillator output enable |
| osc_out | output | 1 | Gated internal oscillator |

## Verification
The assertions assume that every strobe, shift-enable and request input is synchronous to `clk`, so that a strobe edge is detected exactly once. They also assume that a request lasting one cycle is enough to start an operation. The bench drives every input on the falling edge of `clk` and holds each strobe high for exactly one cycle and low for at least one. It pulses each request for a single cycle, and on purpose repeats a request while `busy` is high. Random addresses and data words are mixed with directed cases: address wrap, sector isolation, and program with both requests together.

// File: rtl/ufm_pkg.sv
package ufm_pkg;
    localparam int ADDR_W_DEF     = 9;
    localparam int DATA_W_DEF     = 16;
    localparam int OSC_HALF_DEF   = 2;
    localparam int BUSY_TICKS_DEF = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_BUSY = 1'b1
    } ctl_state_e;

    // Rising-edge detect of a strobe sampled on the system clock
    function automatic logic strobe_rise(input logic now, input logic prev);
        return now & ~prev;
    endfunction

    // Pick the operation to start; program has priority over erase
    function automatic op_e pick_op(input logic prog, input logic erase, input logic busy);
        if (busy)  return OP_NONE;
        if (prog)  return OP_PROG;
        if (erase) return OP_ERASE;
        return OP_NONE;
    endfunction
endpackage

// File: rtl/ufm_addr_sreg.sv
module ufm_addr_sreg
    import ufm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              shift_en,
    input  logic              sin,
    output logic [ADDR_W-1:0] addr
);
    logic sclk_q;
    logic rise;

    assign rise = strobe_rise(sclk, sclk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            addr   <= '0;
        end else begin
            sclk_q <= sclk;
            if (rise) begin
                if (shift_en) addr <= {addr[ADDR_W-2:0], sin};
                else          addr <= addr + 1'b1;
            end
        end
    end

    AST_ADDR_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (rise && shift_en) |=> addr == {$past(addr[ADDR_W-2:0]), $past(sin)}); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rise && !shift_en) |=> addr == $past(addr) + 1'b1); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(addr)); // R2
endmodule

// File: rtl/ufm_data_sreg.sv
module ufm_data_sreg
    import ufm_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              shift_en,
    input  logic              sin,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] dreg,
    output logic              sout
);
    logic sclk_q;
    logic rise;

    assign rise = strobe_rise(sclk, sclk_q);
    assign sout = dreg[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            dreg   <= '0;
        end else begin
            sclk_q <= sclk;
            if (rise) begin
                if (shift_en) dreg <= {dreg[DATA_W-2:0], sin};
                else          dreg <= word_in;
            end
        end
    end

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
        (rise && !shift_en) |=> dreg == $past(word_in)); // R4
    AST_DATA_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (rise && shift_en) |=> dreg == {$past(dreg[DATA_W-2:0]), $past(sin)}); // R5
endmodule

// File: rtl/ufm_op_ctrl.sv
module ufm_op_ctrl
    import ufm_pkg::*;
#(
    parameter int OSC_HALF   = OSC_HALF_DEF,
    parameter int BUSY_TICKS = BUSY_TICKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_req,
    input  logic erase_req,
    output op_e  op_start,
    output logic busy,
    output logic osc_raw
);
    localparam int HW = (OSC_HALF > 1) ? $clog2(OSC_HALF) : 1;
    localparam int CW = $clog2(BUSY_TICKS + 1);

    logic [HW-1:0] half_cnt;
    logic          half_wrap;
    logic          tick;
    ctl_state_e    state;
    logic [CW-1:0] ticks_left;

    assign half_wrap = (half_cnt == HW'(OSC_HALF - 1));
    assign tick      = half_wrap && !osc_raw;   // oscillator about to rise
    assign busy      = (state == CTL_BUSY);
    assign op_start  = pick_op(prog_req, erase_req, busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            osc_raw  <= 1'b0;
        end else if (half_wrap) begin
            half_cnt <= '0;
            osc_raw  <= ~osc_raw;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CTL_IDLE;
            ticks_left <= '0;
        end else begin
            case (state)
                CTL_IDLE: if (op_start != OP_NONE) begin
                    state      <= CTL_BUSY;
                    ticks_left <= CW'(BUSY_TICKS);
                end
                CTL_BUSY: if (tick) begin
                    if (ticks_left <= CW'(1)) state <= CTL_IDLE;
                    ticks_left <= ticks_left - 1'b1;
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && (prog_req || erase_req)) |=> busy); // R8
    AST_TICKS_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ticks_left <= CW'(BUSY_TICKS) && ticks_left != '0)); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (prog_req || erase_req)) |-> ticks_left <= $past(ticks_left)); // R9
    AST_OSC_PERIOD: assert property (@(posedge clk) disable iff (rst)
        !half_wrap |=> $stable(osc_raw)); // R10
endmodule

// File: rtl/ufm_serial_mem.sv
module ufm_serial_mem
    import ufm_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int OSC_HALF   = OSC_HALF_DEF,
    parameter int BUSY_TICKS = BUSY_TICKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_sclk,
    input  logic addr_shift_en,
    input  logic addr_sin,
    input  logic data_sclk,
    input  logic data_shift_en,
    input  logic data_sin,
    output logic data_sout,
    input  logic prog_req,
    input  logic erase_req,
    output logic busy,
    input  logic osc_en,
    output logic osc_out
);
    localparam int WORDS  = 1 << ADDR_W;
    localparam int SECT_W = 1 << (ADDR_W - 1);
    localparam logic [DATA_W-1:0] ERASED = '1;

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dreg;
    logic [DATA_W-1:0] mem [WORDS];
    op_e               op_start;
    logic              osc_raw;

    ufm_addr_sreg #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .sclk(addr_sclk), .shift_en(addr_shift_en),
        .sin(addr_sin), .addr(addr)
    );

    ufm_data_sreg #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst(rst), .sclk(data_sclk), .shift_en(data_shift_en),
        .sin(data_sin), .word_in(mem[addr]), .dreg(dreg), .sout(data_sout)
    );

    ufm_op_ctrl #(.OSC_HALF(OSC_HALF), .BUSY_TICKS(BUSY_TICKS)) u_ctrl (
        .clk(clk), .rst(rst), .prog_req(prog_req), .erase_req(erase_req),
        .op_start(op_start), .busy(busy), .osc_raw(osc_raw)
    );

    assign osc_out = osc_raw & osc_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= ERASED;
        end else begin
            case (op_start)
                OP_PROG:  mem[addr] <= mem[addr] & dreg;
                OP_ERASE: for (int i = 0; i < SECT_W; i++)
                              mem[{addr[ADDR_W-1], i[ADDR_W-2:0]}] <= ERASED;
                default: ;
            endcase
        end
    end

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (op_start == OP_PROG) |=> (mem[$past(addr)] & ~$past(mem[addr])) == '0); // R6
    AST_PROG_APPLIES: assert property (@(posedge clk) disable iff (rst)
        (op_start == OP_PROG) |=> (mem[$past(addr)] & $past(~dreg)) == '0); // R6
    AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (op_start == OP_ERASE) |=> mem[{$past(addr[ADDR_W-1]), {(ADDR_W-1){1'b0}}}] == ERASED); // R7
    AST_ERASE_KEEPS_OTHER: assert property (@(posedge clk) disable iff (rst)
        (op_start == OP_ERASE) |=>
            $stable(mem[{~$past(addr[ADDR_W-1]), {(ADDR_W-1){1'b0}}}])); // R7
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy && (prog_req || erase_req)) |=> $stable(mem[$past(addr)])); // R9
    AST_OSC_GATED: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !osc_out); // R10
endmodule

// File: tb/ufm_serial_mem_tb.sv
module ufm_serial_mem_tb;
    localparam int AW = 9;
    localparam int DW = 16;
    localparam int NW = 512;
    localparam int OSC_HALF = 2;
    localparam int TICKS = 8;
    localparam int PER = 2 * OSC_HALF;

    logic clk = 0;
    logic rst = 1;
    logic addr_sclk = 0, addr_shift_en = 0, addr_sin = 0;
    logic data_sclk = 0, data_shift_en = 0, data_sin = 0;
    logic prog_req = 0, erase_req = 0, osc_en = 0;
    logic data_sout, busy, osc_out;

    int n_run = 0;
    int n_fail = 0;
    logic [DW-1:0] model [NW];
    logic [AW-1:0] cur_addr;

    always #5 clk = ~clk;

    ufm_serial_mem #(.OSC_HALF(OSC_HALF), .BUSY_TICKS(TICKS)) u_dut (
        .clk(clk), .rst(rst), .addr_sclk(addr_sclk), .addr_shift_en(addr_shift_en),
        .addr_sin(addr_sin), .data_sclk(data_sclk), .data_shift_en(data_shift_en),
        .data_sin(data_sin), .data_sout(data_sout), .prog_req(prog_req),
        .erase_req(erase_req), .busy(busy), .osc_en(osc_en), .osc_out(osc_out)
    );

    function automatic logic [DW-1:0] exp_prog(input logic [DW-1:0] old, input logic [DW-1:0] d);
        return old & d;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apulse(input logic sh, input logic b);
        @(negedge clk);
        addr_sclk = 1; addr_shift_en = sh; addr_sin = b;
        @(negedge clk);
        addr_sclk = 0;
    endtask

    task automatic dpulse(input logic sh, input logic b);
        @(negedge clk);
        data_sclk = 1; data_shift_en = sh; data_sin = b;
        @(negedge clk);
        data_sclk = 0;
    endtask

    task automatic set_addr(input logic [AW-1:0] a);
        for (int i = AW - 1; i >= 0; i--) apulse(1'b1, a[i]);
        cur_addr = a;
    endtask

    task automatic step_addr();
        apulse(1'b0, 1'b0);
        cur_addr = cur_addr + 1'b1;
    endtask

    task automatic read_word(output logic [DW-1:0] w);
        dpulse(1'b0, 1'b0);
        for (int i = DW - 1; i >= 0; i--) begin
            w[i] = data_sout;
            dpulse(1'b1, 1'b0);
        end
    endtask

    task automatic load_data(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) dpulse(1'b1, d[i]);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Pulse requests, update model as an accepted operation would, check busy length
    task automatic run_op(input logic p, input logic e, input string req);
        int cyc;
        @(negedge clk);
        prog_req = p; erase_req = e;
        @(negedge clk);
        prog_req = 0; erase_req = 0;
        if (p) model[cur_addr] = exp_prog(model[cur_addr], last_data);
        else if (e)
            for (int i = 0; i < NW; i++)
                if (i[AW-1] == cur_addr[AW-1]) model[i] = '1;
        check({req, " busy raised"}, busy, 1'b1);
        wait_idle(cyc);
        n_run++;
        if (cyc < (TICKS - 1) * PER || cyc > TICKS * PER + 1) begin
            n_fail++;
            $display("FAIL R8: busy cycles actual %0d expected %0d..%0d",
                     cyc + 1, (TICKS - 1) * PER + 1, TICKS * PER + 2);
        end
    endtask

    logic [DW-1:0] last_data;

    task automatic program_at(input logic [AW-1:0] a, input logic [DW-1:0] d);
        set_addr(a);
        load_data(d);
        last_data = d;
        run_op(1'b1, 1'b0, "R6");
    endtask

    task automatic verify(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] w;
        set_addr(a);
        read_word(w);
        check(req, w, model[a]);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        void'($urandom(32'd1234));
        for (int i = 0; i < NW; i++) model[i] = '1;
        cur_addr = '0;
        last_data = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", busy, 1'b0);
        check("R1 sout", data_sout, 1'b0);
        read_word(w);
        check("R1 word0", w, 16'hFFFF);
        check("R1 osc off", osc_out, 1'b0);

        // R10: oscillator gating and period
        osc_en = 1;
        begin
            int ones = 0;
            for (int i = 0; i < 8 * PER; i++) begin
                @(negedge clk);
                ones += osc_out;
            end
            check("R10 duty", ones, 4 * PER);
        end
        osc_en = 0;
        begin
            int ones = 0;
            for (int i = 0; i < 2 * PER; i++) begin
                @(negedge clk);
                ones += osc_out;
            end
            check("R10 gated", ones, 0);
        end

        // R2 R4 R5 R6: program and read back
        program_at(9'h0A5, 16'hA5C3);
        verify(9'h0A5, "R6 prog");
        program_at(9'h0A5, 16'hFF0F);
        verify(9'h0A5, "R6 and");

        // R5: shift through data register
        load_data(16'h8001);
        check("R5 msb", data_sout, 1'b1);
        dpulse(1'b1, 1'b0);
        check("R5 next", data_sout, 1'b0);

        // R3: wrap from 511 to 0
        program_at(9'd0, 16'h1234);
        program_at(9'd511, 16'h00F0);
        set_addr(9'd511);
        step_addr();
        read_word(w);
        check("R3 wrap", w, model[0]);
        step_addr();
        read_word(w);
        check("R3 step", w, model[1]);

        // R7: sector erase keeps other sector
        program_at(9'd300, 16'h0000);
        set_addr(9'd260);
        run_op(1'b0, 1'b1, "R7");
        verify(9'd300, "R7 erased");
        verify(9'd511, "R7 erased top");
        verify(9'd0, "R7 kept");
        verify(9'h0A5, "R7 kept2");

        // R9: request while busy ignored
        set_addr(9'd20);
        load_data(16'h0000);
        last_data = 16'h0000;
        @(negedge clk);
        prog_req = 1;
        @(negedge clk);
        prog_req = 0;
        model[20] = 16'h0000;
        repeat (3) @(negedge clk);
        erase_req = 1;
        @(negedge clk);
        erase_req = 0;
        begin
            int c;
            wait_idle(c);
        end
        verify(9'd20, "R9 erase ignored");

        // R9: both requests while idle -> program wins
        program_at(9'd40, 16'hFFFF);
        set_addr(9'd40);
        load_data(16'h0F0F);
        last_data = 16'h0F0F;
        run_op(1'b1, 1'b1, "R9");
        verify(9'd40, "R9 prog priority");
        verify(9'd20, "R9 no erase");

        // Random program / erase mix with auto-step readback
        for (int it = 0; it < 40; it++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom_range(0, NW - 1));
            d = DW'($urandom);
            if ($urandom_range(0, 9) == 0) begin
                set_addr(a);
                run_op(1'b0, 1'b1, "R7");
            end else begin
                program_at(a, d);
            end
            verify(a, "R6 random");
            step_addr();
            read_word(w);
            check("R3 random step", w, model[cur_addr]);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule